// File: doc/BRIEF.md
# DMA Controller Register File and Interrupt Aggregator

This block is the memory-mapped control and status front end of a multi-channel DMA controller. A plain 32-bit register bus (word address, write strobe, write data, combinational read data) reaches a 4 KB window. Inside that window sit the global configuration and sync words and five words per channel: source address, destination address, link pointer, control and configuration. Each channel's words go out on flattened ports to the transfer engine. The number of channels is a parameter and is either 8 or 2.

The transfer engine reports completion and failure through one-cycle set pulses, one terminal-count bit and one error bit per channel. Those pulses land in raw status registers. Software clears them by writing ones. Two enable bits inside each channel's own configuration word mask the raw bits. The masked bits drive a single level-sensitive interrupt. Soft requests and big-endian master modes are not handled. The soft request words always read as zero.

Top module: `dmac_regfile`

## Requirements
- R1: After reset every register is zero: every mapped offset except the identification words reads 0, `irq` is low, and every channel and global output port is 0.
- R2: Channel n owns byte offsets 0x100+0x20·n+{0x00 source, 0x04 destination, 0x08 link, 0x0C control, 0x10 configuration}. A write there is stored at the clock edge. It reads back unchanged and appears on the matching slice `[n*32 +: 32]` of the channel port from the next cycle.
- R3: In the channel bank, an access to a channel index at or above NUM_CH, or to a word slot above 0x10, is invalid. It reads 0 and a write to it changes nothing.
- R4: Offset 0x30 holds the global configuration and 0x34 the sync word. Both read back what was written and drive `glb_cfg` and `glb_sync`.
- R5: A one on `eng_tc_set[n]` or `eng_err_set[n]` sets raw bit n. The raw terminal-count bits read at 0x14 and the raw error bits at 0x18, in bits [NUM_CH-1:0]. The raw bits hold otherwise.
- R6: A write to 0x08 clears each raw terminal-count bit whose write-data bit is one. A write to 0x10 does the same for raw error bits. Bits written as zero are kept.
- R7: When a set pulse and a software clear hit the same bit in the same cycle, the bit ends up set.
- R8: Bit 15 of channel n's configuration word masks its terminal-count bit, and bit 14 masks its error bit. Offset 0x04 reads raw-TC AND mask, 0x0C reads raw-error AND mask, and 0x00 reads the OR of the two.
- R9: `irq` is high exactly while any masked terminal-count or masked error bit is one.
- R10: Offset 0x1C returns bit 0 of each channel's configuration word, placed at bit position n.
- R11: Word k (k = 0..7) of 0xFE0..0xFFC returns, in bits [7:0], the byte from the list 0x80,0x10,0x04,0x0A,0x0D,0xF0,0x05,0xB1. Word 0 is 0x81 instead when NUM_CH is 2. The upper bits read 0.
- R12: Offsets 0x20..0x2C (soft requests) read 0, and writes to them change no register.
- R13: Any other offset, including the write-only clear words 0x08 and 0x10, reads 0, and writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address in the 4 KB window (bits 1:0 ignored) |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| eng_tc_set | input | NUM_CH | Terminal-count set pulses from the transfer engine |
| eng_err_set | input | NUM_CH | Error set pulses from the transfer engine |
| ch_src | output | NUM_CH*32 | Source address words, channel n at [n*32 +: 32] |
| ch_dst | output | NUM_CH*32 | Destination address words |
| ch_link | output | NUM_CH*32 | Link pointer words |
| ch_ctrl | output | NUM_CH*32 | Control words |
| ch_cfg | output | NUM_CH*32 | Configuration words |
| glb_cfg | output | 32 | Global configuration word |
| glb_sync | output | 32 | Sync word |
| irq | output | 1 | Level interrupt |

## Verification
The bound checker watches these properties on every cycle:
- the interrupt level always matches the raw bits ANDed with the configuration-word masks;
- a set pulse always leaves its bit high one cycle later, even under a same-cycle clear;
- a clear write empties every targeted bit that was not being set;
- the raw bits hold when no set pulse or bus write occurs;
- configuration writes reach the channel port;
- the invalid-channel, soft-request and identification reads keep their zero bits.

The directed scenarios show what only a sequence of accesses can show: read-back of every word class, the value of each identification word, and that writes to soft-request, invalid and unmapped offsets leave the other registers untouched.

// File: rtl/dmac_regs_pkg.sv
package dmac_regs_pkg;

    localparam int DW   = 32;
    localparam int WA_W = 10;

    typedef logic [DW-1:0] word_t;

    // Word slot inside one channel's 32-byte bank
    typedef enum logic [2:0] {
        CW_SRC  = 3'd0,
        CW_DST  = 3'd1,
        CW_LINK = 3'd2,
        CW_CTRL = 3'd3,
        CW_CFG  = 3'd4
    } chan_word_e;

    // Global word addresses (byte offset / 4)
    localparam logic [WA_W-1:0] GW_STAT_ALL = 10'h000;
    localparam logic [WA_W-1:0] GW_STAT_TC  = 10'h001;
    localparam logic [WA_W-1:0] GW_CLR_TC   = 10'h002;
    localparam logic [WA_W-1:0] GW_STAT_ERR = 10'h003;
    localparam logic [WA_W-1:0] GW_CLR_ERR  = 10'h004;
    localparam logic [WA_W-1:0] GW_RAW_TC   = 10'h005;
    localparam logic [WA_W-1:0] GW_RAW_ERR  = 10'h006;
    localparam logic [WA_W-1:0] GW_EN_MAP   = 10'h007;
    localparam logic [WA_W-1:0] GW_GCFG     = 10'h00C;
    localparam logic [WA_W-1:0] GW_SYNC     = 10'h00D;

    // Bank selectors on the word address
    localparam logic [3:0] CHAN_BANK = 4'h1;   // wa[9:6], byte 0x100..0x1FF
    localparam logic [6:0] ID_BANK   = 7'h7F;  // wa[9:3], byte 0xFE0..0xFFF

    // Configuration word bit positions used by the interrupt path
    localparam int TC_MASK_BIT  = 15;
    localparam int ERR_MASK_BIT = 14;
    localparam int EN_BIT       = 0;

    function automatic logic [7:0] id_byte(input logic [2:0] idx, input int nch);
        logic [7:0] b;
        unique case (idx)
            3'd0: b = (nch == 2) ? 8'h81 : 8'h80;
            3'd1: b = 8'h10;
            3'd2: b = 8'h04;
            3'd3: b = 8'h0A;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
    import dmac_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  chan_word_e word_sel,
    input  word_t      wdata,
    output word_t      src_q,
    output word_t      dst_q,
    output word_t      link_q,
    output word_t      ctrl_q,
    output word_t      cfg_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            link_q <= '0;
            ctrl_q <= '0;
            cfg_q  <= '0;
        end else if (wr_en) begin
            case (word_sel)
                CW_SRC:  src_q  <= wdata;
                CW_DST:  dst_q  <= wdata;
                CW_LINK: link_q <= wdata;
                CW_CTRL: ctrl_q <= wdata;
                CW_CFG:  cfg_q  <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dmac_irq_agg.sv
module dmac_irq_agg #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] tc_set,
    input  logic [NUM_CH-1:0] err_set,
    input  logic              tc_clr_wr,
    input  logic              err_clr_wr,
    input  logic [NUM_CH-1:0] clr_bits,
    input  logic [NUM_CH-1:0] tc_msk,
    input  logic [NUM_CH-1:0] err_msk,
    output logic [NUM_CH-1:0] tc_raw,
    output logic [NUM_CH-1:0] err_raw,
    output logic [NUM_CH-1:0] tc_stat,
    output logic [NUM_CH-1:0] err_stat,
    output logic              irq
);

    logic [NUM_CH-1:0] tc_clr_v;
    logic [NUM_CH-1:0] err_clr_v;

    assign tc_clr_v  = tc_clr_wr  ? clr_bits : '0;
    assign err_clr_v = err_clr_wr ? clr_bits : '0;

    // Set is OR-ed after the clear so a same-cycle set survives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_raw  <= '0;
            err_raw <= '0;
        end else begin
            tc_raw  <= (tc_raw  & ~tc_clr_v)  | tc_set;
            err_raw <= (err_raw & ~err_clr_v) | err_set;
        end
    end

    assign tc_stat  = tc_raw  & tc_msk;
    assign err_stat = err_raw & err_msk;
    assign irq      = (|tc_stat) | (|err_stat);

endmodule

// File: rtl/dmac_rd_mux.sv
module dmac_rd_mux
    import dmac_regs_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic [WA_W-1:0]          wa,
    input  logic                     chan_ok,
    input  logic [NUM_CH-1:0][DW-1:0] src_a,
    input  logic [NUM_CH-1:0][DW-1:0] dst_a,
    input  logic [NUM_CH-1:0][DW-1:0] link_a,
    input  logic [NUM_CH-1:0][DW-1:0] ctrl_a,
    input  logic [NUM_CH-1:0][DW-1:0] cfg_a,
    input  logic [NUM_CH-1:0]        tc_raw,
    input  logic [NUM_CH-1:0]        err_raw,
    input  logic [NUM_CH-1:0]        tc_stat,
    input  logic [NUM_CH-1:0]        err_stat,
    input  logic [NUM_CH-1:0]        en_map,
    input  word_t                    gcfg,
    input  word_t                    gsync,
    output word_t                    rdata
);

    always_comb begin
        rdata = '0;
        if (wa[9:6] == CHAN_BANK) begin
            if (chan_ok) begin
                for (int k = 0; k < NUM_CH; k++) begin
                    if (wa[5:3] == 3'(k)) begin
                        case (chan_word_e'(wa[2:0]))
                            CW_SRC:  rdata = src_a[k];
                            CW_DST:  rdata = dst_a[k];
                            CW_LINK: rdata = link_a[k];
                            CW_CTRL: rdata = ctrl_a[k];
                            CW_CFG:  rdata = cfg_a[k];
                            default: rdata = '0;
                        endcase
                    end
                end
            end
        end else if (wa[9:3] == ID_BANK) begin
            rdata = {24'b0, id_byte(wa[2:0], NUM_CH)};
        end else begin
            case (wa)
                GW_STAT_ALL: rdata = DW'(tc_stat | err_stat);
                GW_STAT_TC:  rdata = DW'(tc_stat);
                GW_STAT_ERR: rdata = DW'(err_stat);
                GW_RAW_TC:   rdata = DW'(tc_raw);
                GW_RAW_ERR:  rdata = DW'(err_raw);
                GW_EN_MAP:   rdata = DW'(en_map);
                GW_GCFG:     rdata = gcfg;
                GW_SYNC:     rdata = gsync;
                default:     rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
    import dmac_regs_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [11:0]          bus_addr,
    input  logic                 bus_wr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_CH-1:0]    eng_tc_set,
    input  logic [NUM_CH-1:0]    eng_err_set,
    output logic [NUM_CH*32-1:0] ch_src,
    output logic [NUM_CH*32-1:0] ch_dst,
    output logic [NUM_CH*32-1:0] ch_link,
    output logic [NUM_CH*32-1:0] ch_ctrl,
    output logic [NUM_CH*32-1:0] ch_cfg,
    output logic [31:0]          glb_cfg,
    output logic [31:0]          glb_sync,
    output logic                 irq
);

    logic [WA_W-1:0] wa;
    logic [2:0]      ch_idx;
    logic [2:0]      ch_word;
    logic            chan_ok;

    assign wa      = bus_addr[11:2];
    assign ch_idx  = wa[5:3];
    assign ch_word = wa[2:0];
    assign chan_ok = (wa[9:6] == CHAN_BANK) && (32'(ch_idx) < NUM_CH) && (ch_word <= 3'd4);

    logic [NUM_CH-1:0][DW-1:0] src_a, dst_a, link_a, ctrl_a, cfg_a;
    logic [NUM_CH-1:0]         tc_msk, err_msk, en_map;

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_chan
            dmac_chan_regs u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (bus_wr && chan_ok && (ch_idx == 3'(g))),
                .word_sel(chan_word_e'(ch_word)),
                .wdata   (bus_wdata),
                .src_q   (src_a[g]),
                .dst_q   (dst_a[g]),
                .link_q  (link_a[g]),
                .ctrl_q  (ctrl_a[g]),
                .cfg_q   (cfg_a[g])
            );
            assign tc_msk[g]  = cfg_a[g][TC_MASK_BIT];
            assign err_msk[g] = cfg_a[g][ERR_MASK_BIT];
            assign en_map[g]  = cfg_a[g][EN_BIT];
        end
    endgenerate

    assign ch_src  = src_a;
    assign ch_dst  = dst_a;
    assign ch_link = link_a;
    assign ch_ctrl = ctrl_a;
    assign ch_cfg  = cfg_a;

    // Global configuration and sync words
    word_t gcfg_q, gsync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gcfg_q  <= '0;
            gsync_q <= '0;
        end else if (bus_wr) begin
            if (wa == GW_GCFG) gcfg_q  <= bus_wdata;
            if (wa == GW_SYNC) gsync_q <= bus_wdata;
        end
    end

    assign glb_cfg  = gcfg_q;
    assign glb_sync = gsync_q;

    logic [NUM_CH-1:0] tc_raw, err_raw, tc_stat, err_stat;

    dmac_irq_agg #(.NUM_CH(NUM_CH)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tc_set    (eng_tc_set),
        .err_set   (eng_err_set),
        .tc_clr_wr (bus_wr && (wa == GW_CLR_TC)),
        .err_clr_wr(bus_wr && (wa == GW_CLR_ERR)),
        .clr_bits  (bus_wdata[NUM_CH-1:0]),
        .tc_msk    (tc_msk),
        .err_msk   (err_msk),
        .tc_raw    (tc_raw),
        .err_raw   (err_raw),
        .tc_stat   (tc_stat),
        .err_stat  (err_stat),
        .irq       (irq)
    );

    dmac_rd_mux #(.NUM_CH(NUM_CH)) u_rd (
        .wa      (wa),
        .chan_ok (chan_ok),
        .src_a   (src_a),
        .dst_a   (dst_a),
        .link_a  (link_a),
        .ctrl_a  (ctrl_a),
        .cfg_a   (cfg_a),
        .tc_raw  (tc_raw),
        .err_raw (err_raw),
        .tc_stat (tc_stat),
        .err_stat(err_stat),
        .en_map  (en_map),
        .gcfg    (gcfg_q),
        .gsync   (gsync_q),
        .rdata   (bus_rdata)
    );

    logic unused_addr_bits;
    assign unused_addr_bits = ^{bus_addr[1:0]};

endmodule

// File: rtl/dmac_regfile_chk.sv
module dmac_regfile_chk #(
    parameter int NUM_CH = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [11:0]          bus_addr,
    input logic                 bus_wr,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [NUM_CH-1:0]    eng_tc_set,
    input logic [NUM_CH-1:0]    eng_err_set,
    input logic [NUM_CH*32-1:0] ch_cfg,
    input logic                 irq,
    input logic [NUM_CH-1:0]    tc_raw,
    input logic [NUM_CH-1:0]    err_raw
);

    logic [NUM_CH-1:0] cfg_tc_m, cfg_err_m;
    always_comb begin
        for (int k = 0; k < NUM_CH; k++) begin
            cfg_tc_m[k]  = ch_cfg[k*32 + 15];
            cfg_err_m[k] = ch_cfg[k*32 + 14];
        end
    end

    // R9
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((|(tc_raw & cfg_tc_m)) || (|(err_raw & cfg_err_m))));

    // R7
    tc_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tc_set != '0) |=> ((tc_raw & $past(eng_tc_set)) == $past(eng_tc_set)));

    // R7
    err_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_err_set != '0) |=> ((err_raw & $past(eng_err_set)) == $past(eng_err_set)));

    // R6
    tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[11:2] == 10'h002)
        |=> ((tc_raw & $past(bus_wdata[NUM_CH-1:0]) & ~$past(eng_tc_set)) == '0));

    // R6
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[11:2] == 10'h004)
        |=> ((err_raw & $past(bus_wdata[NUM_CH-1:0]) & ~$past(eng_err_set)) == '0));

    // R5
    raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && eng_tc_set == '0 && eng_err_set == '0) |=> ($stable(tc_raw) && $stable(err_raw)));

    // R3
    bad_chan_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[11:8] == 4'h1 && (32'(bus_addr[7:5]) >= NUM_CH || bus_addr[4:2] > 3'd4))
        |-> (bus_rdata == 32'h0));

    // R12
    soft_req_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[11:4] == 8'h02) |-> (bus_rdata == 32'h0));

    // R11
    id_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[11:5] == 7'h7F) |-> (bus_rdata[31:8] == 24'h0));

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_cfgw
            // R2
            cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr[11:2] == 10'(10'h044 + 8*g))
                |=> (ch_cfg[g*32 +: 32] == $past(bus_wdata)));
        end
    endgenerate

endmodule

bind dmac_regfile dmac_regfile_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .eng_tc_set (eng_tc_set),
    .eng_err_set(eng_err_set),
    .ch_cfg     (ch_cfg),
    .irq        (irq),
    .tc_raw     (tc_raw),
    .err_raw    (err_raw)
);

// File: tb/test_dmac_regfile.sv
`timescale 1ns/1ps
module test_dmac_regfile;

    localparam int NUM_CH = 8;
    localparam int LAST   = NUM_CH - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [11:0]          bus_addr = '0;
    logic                 bus_wr = 1'b0;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          bus_rdata;
    logic [NUM_CH-1:0]    eng_tc_set = '0;
    logic [NUM_CH-1:0]    eng_err_set = '0;
    logic [NUM_CH*32-1:0] ch_src, ch_dst, ch_link, ch_ctrl, ch_cfg;
    logic [31:0]          glb_cfg, glb_sync;
    logic                 irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dmac_regfile #(.NUM_CH(NUM_CH)) i_dmac_regfile (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_tc_set(eng_tc_set), .eng_err_set(eng_err_set),
        .ch_src(ch_src), .ch_dst(ch_dst), .ch_link(ch_link), .ch_ctrl(ch_ctrl),
        .ch_cfg(ch_cfg), .glb_cfg(glb_cfg), .glb_sync(glb_sync), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic pulse(input logic [NUM_CH-1:0] tc, input logic [NUM_CH-1:0] er);
        @(negedge clk);
        eng_tc_set = tc; eng_err_set = er;
        @(negedge clk);
        eng_tc_set = '0; eng_err_set = '0;
    endtask

    function automatic logic [11:0] cadr(input int ch, input int slot);
        return 12'(32'h100 + 32 * ch + 4 * slot);
    endfunction

    function automatic logic [7:0] exp_id(input int k);
        logic [7:0] t [8] = '{8'h80, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        if (k == 0 && NUM_CH == 2) return 8'h81;
        return t[k];
    endfunction

    task automatic t_reset;
        // R1
        rd_chk("R1 status", 12'h000, 32'h0);
        rd_chk("R1 raw tc", 12'h014, 32'h0);
        rd_chk("R1 en map", 12'h01C, 32'h0);
        rd_chk("R1 gcfg", 12'h030, 32'h0);
        rd_chk("R1 ch0 cfg", cadr(0, 4), 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 cfg port", ch_cfg[31:0] | ch_cfg[LAST*32 +: 32], 32'h0);
    endtask

    task automatic t_chan_rw;
        wr(cadr(0, 0), 32'h1234_5678);
        wr(cadr(0, 1), 32'h8765_4321);
        wr(cadr(0, 2), 32'h0000_0A00);
        wr(cadr(LAST, 3), 32'hDEAD_BEEF);
        wr(cadr(LAST, 4), 32'h0000_0001);
        // R2
        rd_chk("R2 src rb", cadr(0, 0), 32'h1234_5678);
        rd_chk("R2 dst rb", cadr(0, 1), 32'h8765_4321);
        rd_chk("R2 link rb", cadr(0, 2), 32'h0000_0A00);
        rd_chk("R2 ctrl rb", cadr(LAST, 3), 32'hDEAD_BEEF);
        chk("R2 src port", ch_src[31:0], 32'h1234_5678);
        chk("R2 ctrl port", ch_ctrl[LAST*32 +: 32], 32'hDEAD_BEEF);
        chk("R2 cfg port", ch_cfg[LAST*32 +: 32], 32'h1);
    endtask

    task automatic t_invalid;
        // R3: word slots above 0x10 are invalid
        wr(cadr(0, 5), 32'hFFFF_FFFF);
        rd_chk("R3 slot5 read", cadr(0, 5), 32'h0);
        rd_chk("R3 src kept", cadr(0, 0), 32'h1234_5678);
        chk("R3 cfg port kept", ch_cfg[31:0], 32'h0);
        if (NUM_CH < 8) begin
            wr(cadr(NUM_CH, 4), 32'hFFFF_FFFF);
            rd_chk("R3 bad idx read", cadr(NUM_CH, 4), 32'h0);
            rd_chk("R3 en map kept", 12'h01C, 32'(1 << LAST));
        end
    endtask

    task automatic t_global;
        wr(12'h030, 32'h0000_0001);
        wr(12'h034, 32'h0000_00A5);
        // R4
        rd_chk("R4 gcfg rb", 12'h030, 32'h1);
        rd_chk("R4 sync rb", 12'h034, 32'hA5);
        chk("R4 gcfg port", glb_cfg, 32'h1);
        chk("R4 sync port", glb_sync, 32'hA5);
    endtask

    task automatic t_enmap;
        // R10
        rd_chk("R10 last only", 12'h01C, 32'(1 << LAST));
        wr(cadr(0, 4), 32'h0000_0001);
        rd_chk("R10 two bits", 12'h01C, 32'((1 << LAST) | 1));
        wr(cadr(0, 4), 32'h0);
        rd_chk("R10 back", 12'h01C, 32'(1 << LAST));
    endtask

    task automatic t_status;
        pulse(NUM_CH'(5), NUM_CH'(2));
        // R5
        rd_chk("R5 raw tc", 12'h014, 32'h5);
        rd_chk("R5 raw err", 12'h018, 32'h2);
        // R8 no masks yet
        rd_chk("R8 masked tc none", 12'h004, 32'h0);
        chk("R9 irq masked off", {31'b0, irq}, 32'h0);
        wr(cadr(0, 4), 32'h0000_8000);
        rd_chk("R8 masked tc", 12'h004, 32'h1);
        rd_chk("R8 combined", 12'h000, 32'h1);
        chk("R9 irq tc", {31'b0, irq}, 32'h1);
        wr(cadr(1, 4), 32'h0000_4000);
        rd_chk("R8 masked err", 12'h00C, 32'h2);
        rd_chk("R8 combined both", 12'h000, 32'h3);
        // R6
        wr(12'h008, 32'h0000_0001);
        rd_chk("R6 tc cleared", 12'h014, 32'h4);
        chk("R9 irq err only", {31'b0, irq}, 32'h1);
        wr(12'h010, 32'h0000_0002);
        rd_chk("R6 err cleared", 12'h018, 32'h0);
        chk("R9 irq low", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_set_wins;
        pulse(NUM_CH'(8), '0);
        rd_chk("R7 pre", 12'h014, 32'hC);
        @(negedge clk);
        bus_addr = 12'h008; bus_wdata = 32'h0000_000C; bus_wr = 1'b1; eng_tc_set = NUM_CH'(4);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; eng_tc_set = '0;
        // R7
        rd_chk("R7 set wins", 12'h014, 32'h4);
    endtask

    task automatic t_id;
        // R11
        for (int k = 0; k < 8; k++)
            rd_chk("R11 id byte", 12'(32'hFE0 + 4 * k), {24'b0, exp_id(k)});
    endtask

    task automatic t_soft_unmapped;
        // R12
        for (int k = 0; k < 4; k++) begin
            wr(12'(32'h020 + 4 * k), 32'hFFFF_FFFF);
            rd_chk("R12 soft read", 12'(32'h020 + 4 * k), 32'h0);
        end
        rd_chk("R12 gcfg kept", 12'h030, 32'h1);
        rd_chk("R12 raw tc kept", 12'h014, 32'h4);
        // R13
        rd_chk("R13 clr word reads 0", 12'h008, 32'h0);
        rd_chk("R13 gap", 12'h040, 32'h0);
        wr(12'h040, 32'hFFFF_FFFF);
        wr(12'h24C, 32'hFFFF_FFFF);
        rd_chk("R13 high gap", 12'h24C, 32'h0);
        rd_chk("R13 sync kept", 12'h034, 32'hA5);
        rd_chk("R13 raw tc kept", 12'h014, 32'h4);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_chan_rw();
        t_invalid();
        t_global();
        t_enmap();
        t_status();
        t_set_wins();
        t_id();
        t_soft_unmapped();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule